// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Warning Interrupt

This block counts timebase ticks while software keeps it running, and escalates in two steps if software stops servicing it. When the running count reaches a programmable warning limit, and warnings are allowed, it raises a level interrupt. This gives software one last chance to recover. When the count reaches a second programmable limit, it issues a one-cycle reset request to the system reset controller. Software services the block by writing to a service register, which returns the count to zero.

A cause flag records that the last reset came from this block. The flag lives in a separate power-on reset domain, so the system reset that the block itself requests does not clear it. Software reads and writes all state through a single-cycle register port. The tick input is a one-cycle enable pulse from a slower timebase.

Top module: `bark_bite_wdog`

## Requirements
- R1: After power-on reset the block is in a known state. The control register reads 0, the cause register reads 0, both limit registers read all ones, the count reads 0, and `warn_irq` and `bite_req` are low.
- R2: The register map is fixed by offset. Offset 0x04 is the service register; a read returns the running count. Offset 0x08 is control: bit 0 is run and bit 1 is warning enable. Offset 0x0C is cause, in bit 0. Offset 0x10 is the warning limit. Offset 0x14 is the bite limit. Any other offset reads 0.
- R3: While run is set, the count rises by exactly one on each clock edge where `tick` is high. While run is clear, the count holds its value.
- R4: A write to the service register with data bit 0 set clears the count and `warn_irq` at the next edge. A write there with bit 0 clear has no effect.
- R5: `warn_irq` rises one cycle after a cycle in which run and warning enable are both set and the count is at or above the warning limit. It never rises while warning enable is clear.
- R6: Once raised, `warn_irq` stays high until a service write, a bite, or the cycle after run is cleared.
- R7: In a cycle where run is set and the count is at or above the bite limit, the next edge raises `bite_req` for exactly one cycle. The same edge clears the count and both control bits.
- R8: The cause flag is set by a bite and survives `rst_n`. Only `por_n` clears it.
- R9: Asserting `rst_n` low returns control, both limits, the count and both outputs to their R1 values, while the cause flag is kept.
- R10: A bite takes priority over a control write or a service write made in the same cycle. Control still reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears everything |
| rst_n | input | 1 | System reset, synchronous, active low; keeps the cause flag |
| tick | input | 1 | Timebase pulse; one count step per high cycle |
| bus_addr | input | AW (8) | Register byte offset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for `bus_addr`, same cycle |
| warn_irq | output | 1 | Warning interrupt level |
| bite_req | output | 1 | One-cycle reset request |

## Verification
Directed sequences separate the main cases from one another:
- running with warning enable clear shows that the count alone cannot raise the interrupt;
- stopping and restarting shows the difference between holding and clearing the count;
- a bite limit of zero, together with a simultaneous control write, shows which of the two wins.

A long random phase then mixes ticks, service writes with either data bit, limit rewrites, control changes and system resets. Short limits make bites frequent. Each cycle is compared with a bench model, so off-by-one errors in the compare, in the warning timing and in reset scope show up as soon as they occur.

// File: rtl/wdog_pkg.sv
// Package: shared offsets and the control register type for the watchdog.
// Assumes byte offsets fit in the bus address width used by the top.
package wdog_pkg;
    localparam int unsigned OFS_SERVICE = 32'h04;
    localparam int unsigned OFS_CTRL    = 32'h08;
    localparam int unsigned OFS_CAUSE   = 32'h0C;
    localparam int unsigned OFS_WARN    = 32'h10;
    localparam int unsigned OFS_BITE    = 32'h14;

    typedef struct packed {
        logic warn_en;
        logic run;
    } wdog_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
// Register file: control, both limits, service decode and read mux.
// Assumes CW <= DW; the read path zero-extends narrower values.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          sys_rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bite_fire,
    input  logic [CW-1:0] count,
    input  logic          cause,
    output wdog_ctrl_t    ctrl,
    output logic [CW-1:0] warn_lim,
    output logic [CW-1:0] bite_lim,
    output logic          svc_req,
    output logic [DW-1:0] bus_rdata
);
    localparam logic [AW-1:0] A_SVC   = AW'(OFS_SERVICE);
    localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_CAUSE = AW'(OFS_CAUSE);
    localparam logic [AW-1:0] A_WARN  = AW'(OFS_WARN);
    localparam logic [AW-1:0] A_BITE  = AW'(OFS_BITE);

    // Service strobe: a write of bit 0 set to the service offset.
    assign svc_req = bus_we && (bus_addr == A_SVC) && bus_wdata[0];

    // Control register; a bite clears it ahead of any write.
    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            ctrl <= '0;
        end else if (bite_fire) begin
            ctrl <= '0;
        end else if (bus_we && (bus_addr == A_CTRL)) begin
            ctrl.run     <= bus_wdata[0];
            ctrl.warn_en <= bus_wdata[1];
        end
    end

    // Limit registers, reset to the largest count.
    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            warn_lim <= '1;
            bite_lim <= '1;
        end else if (bus_we) begin
            if (bus_addr == A_WARN) warn_lim <= bus_wdata[CW-1:0];
            if (bus_addr == A_BITE) bite_lim <= bus_wdata[CW-1:0];
        end
    end

    // Same-cycle read mux.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_SVC:   bus_rdata = DW'(count);
            A_CTRL:  bus_rdata = DW'(ctrl);
            A_CAUSE: bus_rdata = DW'(cause);
            A_WARN:  bus_rdata = DW'(warn_lim);
            A_BITE:  bus_rdata = DW'(bite_lim);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_counter.sv
// Counter and both threshold compares: warning level and bite pulse.
// Assumes tick is a one-cycle pulse; compares are >= so a lowered limit still acts.
module wdog_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          sys_rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          warn_en,
    input  logic          svc_req,
    input  logic [CW-1:0] warn_lim,
    input  logic [CW-1:0] bite_lim,
    output logic [CW-1:0] count,
    output logic          bite_fire,
    output logic          warn_irq,
    output logic          bite_req
);
    logic warn_hit;

    // Threshold compares on the registered count.
    assign bite_fire = run && (count >= bite_lim);
    assign warn_hit  = warn_en && (count >= warn_lim);

    // Running count: bite and service clear it; a tick steps it while running.
    always_ff @(posedge clk) begin
        if (!sys_rst_n)           count <= '0;
        else if (bite_fire)       count <= '0;
        else if (svc_req)         count <= '0;
        else if (run && tick)     count <= count + 1'b1;
    end

    // Sticky warning level, dropped by service, bite or a stopped counter.
    always_ff @(posedge clk) begin
        if (!sys_rst_n)                        warn_irq <= 1'b0;
        else if (bite_fire || svc_req || !run) warn_irq <= 1'b0;
        else if (warn_hit)                     warn_irq <= 1'b1;
    end

    // Reset request: one cycle, since the bite also clears run.
    always_ff @(posedge clk) begin
        if (!sys_rst_n) bite_req <= 1'b0;
        else            bite_req <= bite_fire;
    end
endmodule

// File: rtl/wdog_cause.sv
// Reset-cause flag in the power-on domain; set by a bite.
// Assumes por_n is synchronous to clk.
module wdog_cause (
    input  logic clk,
    input  logic por_n,
    input  logic bite_fire,
    output logic cause
);
    // Sticky flag, cleared only at power-on.
    always_ff @(posedge clk) begin
        if (!por_n)         cause <= 1'b0;
        else if (bite_fire) cause <= 1'b1;
    end
endmodule

// File: rtl/bark_bite_wdog.sv
// Top: two-stage watchdog joining the register file, counter and cause flag.
// Assumes both resets are synchronous and active low; por_n is a superset of rst_n.
module bark_bite_wdog
    import wdog_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          warn_irq,
    output logic          bite_req
);
    logic          sys_rst_n;
    wdog_ctrl_t    ctrl_q;
    logic          run_w;
    logic          warn_en_w;
    logic [CW-1:0] warn_lim_q;
    logic [CW-1:0] bite_lim_q;
    logic [CW-1:0] count_q;
    logic          svc_req;
    logic          bite_fire;
    logic          cause_q;

    assign sys_rst_n = rst_n && por_n;
    assign run_w     = ctrl_q.run;
    assign warn_en_w = ctrl_q.warn_en;

    wdog_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bite_fire (bite_fire),
        .count     (count_q),
        .cause     (cause_q),
        .ctrl      (ctrl_q),
        .warn_lim  (warn_lim_q),
        .bite_lim  (bite_lim_q),
        .svc_req   (svc_req),
        .bus_rdata (bus_rdata)
    );

    wdog_counter #(.CW(CW)) u_cnt (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .tick      (tick),
        .run       (run_w),
        .warn_en   (warn_en_w),
        .svc_req   (svc_req),
        .warn_lim  (warn_lim_q),
        .bite_lim  (bite_lim_q),
        .count     (count_q),
        .bite_fire (bite_fire),
        .warn_irq  (warn_irq),
        .bite_req  (bite_req)
    );

    wdog_cause u_cause (
        .clk       (clk),
        .por_n     (por_n),
        .bite_fire (bite_fire),
        .cause     (cause_q)
    );
endmodule

// File: rtl/wdog_checker.sv
// Checker: temporal properties of the watchdog, bound to the top.
// Assumes the bound signals are the top's internal nets of the same names.
module wdog_checker #(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          por_n,
    input logic          rst_n,
    input logic          warn_irq,
    input logic          bite_req,
    input logic [CW-1:0] count_q,
    input logic          run_w,
    input logic          warn_en_w,
    input logic          svc_req,
    input logic          bite_fire,
    input logic          cause_q
);
    a_r7_bite_single: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
        bite_req |=> !bite_req);
    a_r7_bite_clears: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
        bite_req |-> (count_q == '0) && !run_w);
    a_r6_warn_drops_on_bite: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
        bite_req |-> !warn_irq);
    a_r4_service_clears: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
        (svc_req && !bite_fire) |=> (count_q == '0) && !warn_irq);
    a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
        (!run_w && !svc_req) |=> $stable(count_q));
    a_r5_warn_needs_enable: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
        $rose(warn_irq) |-> $past(warn_en_w) && $past(run_w));
    a_r8_cause_sticky: assert property (@(posedge clk) disable iff (!por_n)
        cause_q |=> cause_q);
    a_r8_cause_on_bite: assert property (@(posedge clk) disable iff (!(rst_n && por_n))
        bite_req |-> cause_q);
endmodule

bind bark_bite_wdog wdog_checker #(.CW(CW)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .warn_irq  (warn_irq),
    .bite_req  (bite_req),
    .count_q   (count_q),
    .run_w     (run_w),
    .warn_en_w (warn_en_w),
    .svc_req   (svc_req),
    .bite_fire (bite_fire),
    .cause_q   (cause_q)
);

// File: tb/bark_bite_wdog_tb.sv
module bark_bite_wdog_tb;
    localparam logic [7:0] A_SVC = 8'h04, A_CTRL = 8'h08, A_CAUSE = 8'h0C,
                           A_WARN = 8'h10, A_BITE = 8'h14;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        warn_irq, bite_req;

    int total = 0, fails = 0;

    // bench model state
    logic [31:0] m_cnt, m_warn, m_lim;
    logic        m_run, m_wen, m_warn_irq, m_bite, m_cause;

    always #2.5 clk = ~clk;

    bark_bite_wdog u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .warn_irq(warn_irq), .bite_req(bite_req)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mread(logic [7:0] a);
        case (a)
            A_SVC:   return m_cnt;
            A_CTRL:  return {30'd0, m_wen, m_run};
            A_CAUSE: return {31'd0, m_cause};
            A_WARN:  return m_warn;
            A_BITE:  return m_lim;
            default: return 32'd0;
        endcase
    endfunction

    task automatic mstep(logic [7:0] a, logic we, logic [31:0] d, logic tk);
        logic fire, svc;
        fire = m_run && (m_cnt >= m_lim);
        if (!por_n || !rst_n) begin
            m_cause = por_n ? (m_cause | fire) : 1'b0;
            m_cnt = 0; m_run = 0; m_wen = 0; m_warn_irq = 0; m_bite = 0;
            m_warn = '1; m_lim = '1;
        end else begin
            svc = we && (a == A_SVC) && d[0];
            if (fire || svc || !m_run) m_warn_irq = 1'b0;
            else if (m_wen && m_cnt >= m_warn) m_warn_irq = 1'b1;
            if (fire || svc) m_cnt = 0;
            else if (m_run && tk) m_cnt = m_cnt + 1;
            if (fire) begin m_run = 0; m_wen = 0; end
            else if (we && a == A_CTRL) begin m_run = d[0]; m_wen = d[1]; end
            if (we && a == A_WARN) m_warn = d;
            if (we && a == A_BITE) m_lim = d;
            m_bite = fire;
            m_cause = m_cause | fire;
        end
    endtask

    // One cycle: drive at negedge, compare, step the model at posedge.
    task automatic cycx(logic [7:0] a, logic we, logic [31:0] d, logic tk,
                        bit has_exp, logic [31:0] exp, string tag);
        bus_addr = a; bus_we = we; bus_wdata = d; tick = tk;
        #1;
        if (has_exp) chk(tag, bus_rdata, exp);
        chk("R2 read data", bus_rdata, mread(a));
        chk("R5 warn_irq", {31'd0, warn_irq}, {31'd0, m_warn_irq});
        chk("R7 bite_req", {31'd0, bite_req}, {31'd0, m_bite});
        @(posedge clk);
        mstep(a, we, d, tk);
        @(negedge clk);
    endtask

    task automatic cyc(logic [7:0] a, logic we, logic [31:0] d, logic tk);
        cycx(a, we, d, tk, 1'b0, 32'd0, "");
    endtask

    task automatic peek(logic [7:0] a, logic [31:0] exp, string tag);
        cycx(a, 1'b0, 32'd0, 1'b0, 1'b1, exp, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        m_cause = 0;
        @(negedge clk);
        // R1: power-on reset
        por_n = 0; rst_n = 0;
        repeat (3) cyc(8'h00, 0, 0, 0);
        por_n = 1; rst_n = 1;
        peek(A_CTRL,  32'd0, "R1 ctrl reset");
        peek(A_CAUSE, 32'd0, "R1 cause reset");
        peek(A_WARN,  32'hFFFF_FFFF, "R1 warn limit reset");
        peek(A_BITE,  32'hFFFF_FFFF, "R1 bite limit reset");
        peek(A_SVC,   32'd0, "R1 count reset");
        peek(8'h18,   32'd0, "R2 unmapped offset");
        chk("R1 outputs low", {30'd0, warn_irq, bite_req}, 32'd0);

        // R3/R5: run without warning enable
        cyc(A_WARN, 1, 32'd2, 0);
        cyc(A_BITE, 1, 32'd100, 0);
        cyc(A_CTRL, 1, 32'd1, 0);
        repeat (5) cyc(A_SVC, 0, 0, 1);
        peek(A_SVC, 32'd5, "R3 five ticks");
        chk("R5 no warn without enable", {31'd0, warn_irq}, 32'd0);
        cyc(A_CTRL, 1, 32'd3, 0);
        cyc(A_SVC, 0, 0, 0);
        chk("R5 warn raised", {31'd0, warn_irq}, 32'd1);
        repeat (3) cyc(A_SVC, 0, 0, 0);
        chk("R6 warn held", {31'd0, warn_irq}, 32'd1);
        // R6: stop drops warning; R3 count holds
        cyc(A_CTRL, 1, 32'd0, 0);
        cyc(A_SVC, 0, 0, 1);
        chk("R6 warn dropped by stop", {31'd0, warn_irq}, 32'd0);
        cyc(A_SVC, 0, 0, 1);
        peek(A_SVC, 32'd5, "R3 count held while stopped");
        // R4: service writes
        cyc(A_SVC, 1, 32'd0, 0);
        peek(A_SVC, 32'd5, "R4 service with bit0 clear ignored");
        cyc(A_SVC, 1, 32'd1, 0);
        peek(A_SVC, 32'd0, "R4 service clears count");

        // R7/R8: bite
        cyc(A_BITE, 1, 32'd4, 0);
        cyc(A_CTRL, 1, 32'd3, 0);
        for (int i = 0; i < 20 && !bite_req; i++) cyc(A_SVC, 0, 0, 1);
        chk("R7 bite pulse seen", {31'd0, bite_req}, 32'd1);
        peek(A_CTRL, 32'd0, "R7 control cleared by bite");
        chk("R7 bite single cycle", {31'd0, bite_req}, 32'd0);
        peek(A_SVC, 32'd0, "R7 count cleared by bite");
        peek(A_CAUSE, 32'd1, "R8 cause set");

        // R9: system reset keeps cause
        rst_n = 0; cyc(8'h00, 0, 0, 0); rst_n = 1;
        peek(A_CAUSE, 32'd1, "R8 cause survives rst_n");
        peek(A_BITE, 32'hFFFF_FFFF, "R9 limit reset by rst_n");
        por_n = 0; cyc(8'h00, 0, 0, 0); por_n = 1;
        peek(A_CAUSE, 32'd0, "R8 cause cleared by por_n");

        // R10: zero bite limit, control write in the firing cycle
        cyc(A_BITE, 1, 32'd0, 0);
        cyc(A_CTRL, 1, 32'd1, 0);
        cyc(A_CTRL, 1, 32'd3, 0);
        chk("R10 bite fired", {31'd0, bite_req}, 32'd1);
        peek(A_CTRL, 32'd0, "R10 bite beats control write");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic tk;
            r = $urandom_range(0, 99);
            tk = 1'($urandom_range(0, 1));
            if (r < 4)       cyc(A_SVC, 1, 32'd1, tk);
            else if (r < 6)  cyc(A_SVC, 1, 32'd0, tk);
            else if (r < 10) cyc(A_CTRL, 1, ($urandom_range(0, 2) == 0) ? 32'($urandom_range(0, 3)) : 32'd3, tk);
            else if (r < 12) cyc(A_WARN, 1, 32'($urandom_range(1, 15)), tk);
            else if (r < 14) cyc(A_BITE, 1, 32'($urandom_range(0, 30)), tk);
            else if (r < 15) begin rst_n = 0; cyc(A_CAUSE, 0, 0, tk); rst_n = 1; end
            else             cyc(8'(4 * $urandom_range(0, 6)), 0, 0, tk);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule